// File: doc/BRIEF.md
# Pattern Playback and Capture Sequencer

This controller drives one outgoing pattern buffer and one incoming capture buffer of a test fixture. A run is launched either by a rising edge of a software start bit in the control word or by a rising edge on an external start pin; a mode bit in the same word picks which of the two is active. During a run the controller streams words out of the pattern buffer toward the device under test and writes words coming back from the device into the capture buffer.

Playback is held off until the pattern buffer holds more words than its almost-empty threshold. Once started, it drains the buffer to empty. Capture waits a programmable number of clock cycles after the start, then writes one word per cycle until the capture buffer reports full. The run indicator drops once both halves have finished. The last word played stays on the pattern output until a later playback replaces it. Four active-low buffer reset lines are taken from the control word and passed through, and a start is refused while any of them is asserted.

Top module: `pbc_sequencer`

## Requirements
- R1: With control bit 30 at 0, a 0-to-1 change of control bit 31 between two clock edges raises `run_active` in the following cycle.
- R2: With control bit 30 at 1, only a rising edge of `ext_start` starts a run, and changes of control bit 31 start nothing.
- R3: With write delay D in control bits 23:16, the first `cap_wr` occurs exactly D+1 cycles after the first cycle in which `run_active` is high, as long as the capture buffer is not full.
- R4: During a run, `pat_rd` stays low until `pat_almost_empty` has been seen low once. After that, `pat_almost_empty` no longer affects playback.
- R5: Once playback has begun, `pat_rd` is high in every cycle in which `pat_empty` is low, and playback ends for the run when `pat_empty` is seen high.
- R6: After the delay, `cap_wr` is high in every cycle in which `cap_full` is low, with `cap_wdata` equal to `dut_data` in that cycle.
- R7: Capture ends for the run when `cap_full` is seen high, and `cap_wr` is never high while `cap_full` is high.
- R8: `run_active` falls one cycle after playback and capture have both finished. Start edges that arrive while a run is active are ignored.
- R9: `pat_out` takes the `pat_rdata` value of each cycle in which `pat_rd` is high, holds it otherwise, and is 0 after reset.
- R10: `ch0_clk_en` follows control bit 29.
- R11: The reset lines follow the control word: bit 15 to `cap_prst_n`, bit 14 to `cap_mrst_n`, bit 13 to `pat_prst_n` and bit 12 to `pat_mrst_n`, all active low. A start edge is ignored while any of these bits is 0.
- R12: After `rst`, `run_active`, `pat_rd` and `cap_wr` are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Control word (start bit, mode, channel 0 clock enable, write delay, buffer resets) |
| ext_start | input | 1 | External start, active on its rising edge when selected |
| pat_empty | input | 1 | Pattern buffer empty flag |
| pat_almost_empty | input | 1 | Pattern buffer at or below its almost-empty threshold |
| pat_rdata | input | 18 | Word at the head of the pattern buffer |
| cap_full | input | 1 | Capture buffer full flag |
| dut_data | input | 18 | Data returned by the device under test |
| pat_rd | output | 1 | Pattern buffer read strobe |
| cap_wr | output | 1 | Capture buffer write strobe |
| cap_wdata | output | 18 | Word written into the capture buffer |
| pat_out | output | 18 | Last word played toward the device |
| run_active | output | 1 | High while a run is in progress |
| ch0_clk_en | output | 1 | Clock enable for channel 0 |
| cap_prst_n | output | 1 | Capture buffer partial reset, active low |
| cap_mrst_n | output | 1 | Capture buffer master reset, active low |
| pat_prst_n | output | 1 | Pattern buffer partial reset, active low |
| pat_mrst_n | output | 1 | Pattern buffer master reset, active low |

## Verification
If the playback phase register goes wrong, the error shows up on `pat_rd` in the same cycle: a read comes too early while the buffer is still near empty, or reads stop before the buffer is drained. A wrong delay count moves the first `cap_wr` by one or more cycles. A run flag that does not clear leaves `run_active` high and blocks the next start. Because the bench compares every strobe, `pat_out` and `run_active` against its own model on each clock, any of these faults is reported in the first cycle in which it reaches a port.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int DATA_W = 18;
    localparam int DLY_W  = 8;

    // Control word layout, most significant bit first (32 bits).
    typedef struct packed {
        logic             sw_go;       // 31: software start, acts on 0->1
        logic             ext_mode;    // 30: 1 = external pin starts a run
        logic             ch0_en;      // 29: channel 0 clock enable
        logic [4:0]       spare;       // 28:24
        logic [DLY_W-1:0] wr_delay;    // 23:16: cycles before first capture write
        logic             cap_prst_n;  // 15
        logic             cap_mrst_n;  // 14
        logic             pat_prst_n;  // 13
        logic             pat_mrst_n;  // 12
        logic [5:0]       rb_delay;    // 11:6: analog delay, handled outside
        logic [5:0]       ch0_delay;   // 5:0: analog delay, handled outside
    } ctrl_t;

    typedef enum logic [1:0] {
        PB_IDLE = 2'd0,
        PB_HOLD = 2'd1,
        PB_PLAY = 2'd2,
        PB_DONE = 2'd3
    } pb_state_t;

    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_DELAY = 2'd1,
        CP_FILL  = 2'd2,
        CP_DONE  = 2'd3
    } cp_state_t;

    function automatic logic resets_released(ctrl_t c);
        return c.cap_prst_n & c.cap_mrst_n & c.pat_prst_n & c.pat_mrst_n;
    endfunction

endpackage

// File: rtl/pbc_start_detect.sv
module pbc_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic sw_bit,
    input  logic ext_in,
    output logic start_edge
);
    logic sw_q;
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q  <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            sw_q  <= sw_bit;
            ext_q <= ext_in;
        end
    end

    always_comb begin
        if (ext_mode) start_edge = ext_in & ~ext_q;
        else          start_edge = sw_bit & ~sw_q;
    end
endmodule

// File: rtl/pbc_playback.sv
module pbc_playback
    import pbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic finish,
    input  logic almost_empty,
    input  logic empty,
    output logic rd,
    output logic done
);
    pb_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PB_IDLE;
        end else begin
            unique case (state)
                PB_IDLE: if (launch)        state <= PB_HOLD;
                PB_HOLD: if (!almost_empty) state <= PB_PLAY;
                PB_PLAY: if (empty)         state <= PB_DONE;
                PB_DONE: if (finish)        state <= PB_IDLE;
                default:                    state <= PB_IDLE;
            endcase
        end
    end

    assign rd   = (state == PB_PLAY) && !empty;
    assign done = (state == PB_DONE);

    // R5: playback only finishes after the buffer was seen empty
    a_r5_done_after_empty: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(empty));

    // R4: a read never follows directly on a hold cycle with the threshold unmet
    a_r4_hold_blocks_read: assert property (@(posedge clk) disable iff (rst)
        (state == PB_HOLD) && almost_empty |=> !rd);
endmodule

// File: rtl/pbc_capture.sv
module pbc_capture
    import pbc_pkg::*;
#(
    parameter int CNT_W = DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             finish,
    input  logic [CNT_W-1:0] delay,
    input  logic             full,
    output logic             wr,
    output logic             done
);
    cp_state_t        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CP_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                CP_IDLE: if (launch) begin
                    state <= CP_DELAY;
                    cnt   <= delay;
                end
                CP_DELAY: begin
                    if (cnt == '0) state <= CP_FILL;
                    else           cnt   <= cnt - 1'b1;
                end
                CP_FILL: if (full)   state <= CP_DONE;
                CP_DONE: if (finish) state <= CP_IDLE;
                default:             state <= CP_IDLE;
            endcase
        end
    end

    assign wr   = (state == CP_FILL) && !full;
    assign done = (state == CP_DONE);

    // R3: while the delay count is running, no write can appear next cycle
    a_r3_delay_no_write: assert property (@(posedge clk) disable iff (rst)
        (state == CP_DELAY) && (cnt != '0) |=> !wr);

    // R7: capture only finishes after the buffer was seen full
    a_r7_done_after_full: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(full));
endmodule

// File: rtl/pbc_sequencer.sv
module pbc_sequencer
    import pbc_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ctrl_word,
    input  logic              ext_start,
    input  logic              pat_empty,
    input  logic              pat_almost_empty,
    input  logic [WORD_W-1:0] pat_rdata,
    input  logic              cap_full,
    input  logic [WORD_W-1:0] dut_data,
    output logic              pat_rd,
    output logic              cap_wr,
    output logic [WORD_W-1:0] cap_wdata,
    output logic [WORD_W-1:0] pat_out,
    output logic              run_active,
    output logic              ch0_clk_en,
    output logic              cap_prst_n,
    output logic              cap_mrst_n,
    output logic              pat_prst_n,
    output logic              pat_mrst_n
);
    ctrl_t ctl;
    assign ctl = ctrl_t'(ctrl_word);

    logic start_edge;
    logic launch;
    logic finish;
    logic pb_done;
    logic cp_done;
    logic run_q;

    pbc_start_detect u_start (
        .clk        (clk),
        .rst        (rst),
        .ext_mode   (ctl.ext_mode),
        .sw_bit     (ctl.sw_go),
        .ext_in     (ext_start),
        .start_edge (start_edge)
    );

    assign launch = start_edge && !run_q && resets_released(ctl);
    assign finish = run_q && pb_done && cp_done;

    pbc_playback u_play (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .finish       (finish),
        .almost_empty (pat_almost_empty),
        .empty        (pat_empty),
        .rd           (pat_rd),
        .done         (pb_done)
    );

    pbc_capture #(.CNT_W(DLY_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .finish (finish),
        .delay  (ctl.wr_delay),
        .full   (cap_full),
        .wr     (cap_wr),
        .done   (cp_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            pat_out <= '0;
        end else begin
            if (launch)      run_q <= 1'b1;
            else if (finish) run_q <= 1'b0;
            if (pat_rd) pat_out <= pat_rdata;
        end
    end

    assign run_active = run_q;
    assign cap_wdata  = dut_data;
    assign ch0_clk_en = ctl.ch0_en;
    assign cap_prst_n = ctl.cap_prst_n;
    assign cap_mrst_n = ctl.cap_mrst_n;
    assign pat_prst_n = ctl.pat_prst_n;
    assign pat_mrst_n = ctl.pat_mrst_n;

    // R1: a run only begins after a detected start edge
    a_r1_run_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(run_active) |-> $past(start_edge));

    // R11: a run only begins while every buffer reset bit is released
    a_r11_no_start_in_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(run_active) |-> $past(ctrl_word[15:12] == 4'hF));

    // R4: no pattern read outside a run
    a_r4_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        !run_active |-> !pat_rd);

    // R7: never write into a full capture buffer
    a_r7_no_write_full: assert property (@(posedge clk) disable iff (rst)
        cap_wr |-> !cap_full);

    // R9: pattern output holds when nothing is read
    a_r9_pat_hold: assert property (@(posedge clk) disable iff (rst)
        !pat_rd |=> $stable(pat_out));

    // R8: an active run with unfinished work stays active
    a_r8_run_holds: assert property (@(posedge clk) disable iff (rst)
        run_active && !(pb_done && cp_done) |=> run_active);
endmodule

// File: tb/pbc_sequencer_bench.sv
module pbc_sequencer_bench;
    localparam int W      = 18;
    localparam int AE_THR = 4;
    localparam int IDEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   ctrl_word = 32'h0000_F000;
    logic          ext_start = 1'b0;
    logic          pat_empty = 1'b1;
    logic          pat_almost_empty = 1'b1;
    logic [W-1:0]  pat_rdata = '0;
    logic          cap_full = 1'b0;
    logic [W-1:0]  dut_data = '0;
    logic          pat_rd, cap_wr, run_active, ch0_clk_en;
    logic [W-1:0]  cap_wdata, pat_out;
    logic          cap_prst_n, cap_mrst_n, pat_prst_n, pat_mrst_n;

    pbc_sequencer u_pbc_sequencer (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_start(ext_start),
        .pat_empty(pat_empty), .pat_almost_empty(pat_almost_empty),
        .pat_rdata(pat_rdata), .cap_full(cap_full), .dut_data(dut_data),
        .pat_rd(pat_rd), .cap_wr(cap_wr), .cap_wdata(cap_wdata),
        .pat_out(pat_out), .run_active(run_active), .ch0_clk_en(ch0_clk_en),
        .cap_prst_n(cap_prst_n), .cap_mrst_n(cap_mrst_n),
        .pat_prst_n(pat_prst_n), .pat_mrst_n(pat_mrst_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [W-1:0] oq[$];
    logic [W-1:0] iq[$];

    // reference model state
    bit           m_run = 0;
    int           m_play = 0;   // 0 idle, 1 waiting for threshold, 2 playing, 3 finished
    int           m_cap  = 0;   // 0 idle, 1 delaying, 2 filling, 3 finished
    int           m_cnt  = 0;
    bit           m_sw_prev = 0, m_ext_prev = 0;
    logic [W-1:0] m_pat = '0;

    // snapshot taken between edges
    logic [31:0]  s_ctrl;
    logic         s_ext, s_ae, s_empty, s_full, s_rd, s_wr;
    logic [W-1:0] s_rdata, s_dut;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic refresh_flags();
        pat_empty        = (oq.size() == 0);
        pat_almost_empty = (oq.size() <= AE_THR);
        if (oq.size() != 0) pat_rdata = oq[0];
        cap_full         = (iq.size() >= IDEPTH);
    endtask

    // compare every cycle, then advance model and buffers at the edge
    always begin
        @(negedge clk);
        s_ctrl = ctrl_word; s_ext = ext_start; s_ae = pat_almost_empty;
        s_empty = pat_empty; s_full = cap_full; s_rdata = pat_rdata;
        s_dut = dut_data; s_rd = pat_rd; s_wr = cap_wr;
        if (!rst) begin
            bit e_rd, e_wr;
            e_rd = m_run && m_play == 2 && !s_empty;
            e_wr = m_run && m_cap == 2 && !s_full;
            check(pat_rd == e_rd, "R5", "pat_rd", pat_rd, e_rd);
            check(cap_wr == e_wr, "R6", "cap_wr", cap_wr, e_wr);
            check(run_active == m_run, "R8", "run_active", run_active, m_run);
            check(pat_out == m_pat, "R9", "pat_out", pat_out, m_pat);
            check(ch0_clk_en == s_ctrl[29], "R10", "ch0_clk_en", ch0_clk_en, s_ctrl[29]);
            check({cap_prst_n, cap_mrst_n, pat_prst_n, pat_mrst_n} == s_ctrl[15:12],
                  "R11", "reset lines",
                  {cap_prst_n, cap_mrst_n, pat_prst_n, pat_mrst_n}, s_ctrl[15:12]);
            if (cap_wr) check(cap_wdata == s_dut, "R6", "cap_wdata", cap_wdata, s_dut);
        end
        @(posedge clk);
        #1;
        if (rst) begin
            m_run = 0; m_play = 0; m_cap = 0; m_cnt = 0;
            m_sw_prev = 0; m_ext_prev = 0; m_pat = '0;
        end else begin
            bit go;
            if (m_run && m_play == 2 && !s_empty) m_pat = s_rdata;
            go = s_ctrl[30] ? (s_ext && !m_ext_prev) : (s_ctrl[31] && !m_sw_prev);
            m_sw_prev = s_ctrl[31];
            m_ext_prev = s_ext;
            if (!m_run) begin
                if (go && s_ctrl[15:12] == 4'hF) begin
                    m_run = 1; m_play = 1; m_cap = 1; m_cnt = int'(s_ctrl[23:16]);
                end
            end else if (m_play == 3 && m_cap == 3) begin
                m_run = 0; m_play = 0; m_cap = 0;
            end else begin
                if (m_play == 1 && !s_ae) m_play = 2;
                else if (m_play == 2 && s_empty) m_play = 3;
                if (m_cap == 1) begin
                    if (m_cnt == 0) m_cap = 2;
                    else m_cnt--;
                end else if (m_cap == 2 && s_full) m_cap = 3;
            end
        end
        if (s_rd && oq.size() != 0) void'(oq.pop_front());
        if (s_wr) iq.push_back(s_dut);
        refresh_flags();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 40000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // stimulus acts 2 ns after each rising edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
        dut_data = dut_data + 18'h00101;
    endtask

    task automatic load(input int n, input logic [W-1:0] base);
        for (int i = 0; i < n; i++) oq.push_back(base + W'(i));
        refresh_flags();
    endtask

    task automatic drain_capture();
        iq.delete();
        refresh_flags();
    endtask

    task automatic sw_start();
        ctrl_word[31] = 1'b0; tick(1);
        ctrl_word[31] = 1'b1; tick(1);
    endtask

    task automatic wait_idle();
        while (run_active) tick(1);
    endtask

    initial begin
        refresh_flags();
        tick(3);
        rst = 1'b0;
        tick(1);
        // R12: quiet after reset
        check(run_active == 0 && pat_rd == 0 && cap_wr == 0, "R12", "post-reset strobes",
              {run_active, pat_rd, cap_wr}, 0);
        check(pat_out == 0, "R12", "post-reset pat_out", pat_out, 0);

        // R1 R5 R7 R9: software start, delay 3, ten pattern words
        ctrl_word = 32'h2003_F000;
        load(10, 18'h2A000);
        sw_start();
        check(run_active == 1, "R1", "run after software edge", run_active, 1);
        wait_idle();
        check(oq.size() == 0, "R5", "pattern buffer drained", oq.size(), 0);
        check(iq.size() == IDEPTH, "R7", "capture filled to full", iq.size(), IDEPTH);
        check(pat_out == 18'h2A009, "R9", "last word held", pat_out, 18'h2A009);
        tick(4);
        check(pat_out == 18'h2A009, "R9", "hold after run", pat_out, 18'h2A009);

        // R4: threshold not met, playback waits while capture finishes
        drain_capture();
        ctrl_word[29] = 1'b0;
        ctrl_word[23:16] = 8'd1;
        load(3, 18'h01000);
        sw_start();
        tick(20);
        check(run_active == 1, "R4", "run waits on threshold", run_active, 1);
        check(oq.size() == 3, "R4", "no reads below threshold", oq.size(), 3);
        load(5, 18'h01100);
        wait_idle();
        check(oq.size() == 0, "R4", "plays all once threshold passed", oq.size(), 0);
        check(pat_out == 18'h01104, "R9", "last of second load", pat_out, 18'h01104);

        // R2: external mode ignores bit 31, then starts on the pin
        drain_capture();
        ctrl_word[30] = 1'b1;
        load(6, 18'h03000);
        sw_start();
        tick(4);
        check(run_active == 0, "R2", "bit 31 ignored in external mode", run_active, 0);
        ext_start = 1'b1; tick(1);
        ext_start = 1'b0;
        check(run_active == 1, "R2", "external edge starts", run_active, 1);
        // R8: another edge during the run is ignored
        tick(1);
        ext_start = 1'b1; tick(1);
        ext_start = 1'b0;
        wait_idle();
        tick(3);
        check(run_active == 0, "R8", "no restart from edge during run", run_active, 0);

        // R11: a held reset bit blocks the start
        drain_capture();
        ctrl_word[30] = 1'b0;
        ctrl_word[12] = 1'b0;
        load(6, 18'h04000);
        sw_start();
        tick(3);
        check(run_active == 0, "R11", "start refused under reset", run_active, 0);
        check(pat_mrst_n == 0, "R11", "pattern master reset line", pat_mrst_n, 0);
        ctrl_word[12] = 1'b1;
        tick(1);

        // R3: first write exactly D+1 cycles after run starts, D = 0 and D = 5
        for (int k = 0; k < 2; k++) begin
            int d, n;
            d = (k == 0) ? 0 : 5;
            drain_capture();
            ctrl_word[23:16] = 8'(d);
            if (oq.size() <= AE_THR) load(6, 18'h05000);
            sw_start();
            n = 0;
            while (!cap_wr && n < 300) begin tick(1); n++; end
            check(n == d + 1, "R3", "first write offset", n, d + 1);
            wait_idle();
        end

        // R7: capture buffer already full, capture ends at once
        drain_capture();
        for (int i = 0; i < IDEPTH; i++) iq.push_back('0);
        refresh_flags();
        ctrl_word[23:16] = 8'd0;
        load(6, 18'h06000);
        sw_start();
        wait_idle();
        check(iq.size() == IDEPTH, "R7", "no write into full buffer", iq.size(), IDEPTH);
        check(ch0_clk_en == 0, "R10", "channel 0 enable off", ch0_clk_en, 0);

        tick(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule